// File: doc/BRIEF.md
# Parallel-Prefix Binary Adder

This block adds two unsigned WIDTH-bit operands and a carry-in with no clock and no state. Each bit position first forms a generate flag (both operand bits set) and a propagate flag (operand bits differ). A prefix network then combines these flags with an associative carry operator, so that every carry is formed at once rather than rippled bit by bit. The operator merges a more significant pair with a less significant pair: the group generates when the upper part generates, or when the upper part propagates and the lower part generates. The group propagates only when both parts propagate. Operand order is kept in every cell, because the operator is not commutative.

A parameter picks the shape of the network. `TREE_DENSE` uses log2(WIDTH) operator levels, and each cell drives at most two others. `TREE_SPARSE` builds an upward pass and then a downward fill-in pass. This uses far fewer cells, with about twice the logic depth. Both settings give the same outputs for every input. The carry-in is folded into the lowest prefix position. The final XOR stage adds each bit's propagate to the carry entering it. The whole carry vector is brought out so that neighbouring logic can observe it.

Top module: `pp_adder`

## Requirements
- R1: `{cout_o, sum_o}` equals `a_i + b_i + cin_i` as an unsigned (WIDTH+1)-bit sum, for every input.
- R2: `carry_o[0]` equals `cin_i` and `carry_o[WIDTH]` equals `cout_o`.
- R3: for 1 <= k <= WIDTH, `carry_o[k]` is the carry out of the low k bits, that is bit k of `a_i[k-1:0] + b_i[k-1:0] + cin_i`.
- R4: every sum bit satisfies `sum_o[k] = a_i[k] ^ b_i[k] ^ carry_o[k]`.
- R5: when every bit propagates (`a_i ^ b_i` all ones) and `cin_i` = 1, the carry runs the full width: `sum_o` is zero, `cout_o` is 1 and every bit of `carry_o` is 1.
- R6: when every bit propagates and `cin_i` = 0, `sum_o` is all ones and every bit of `carry_o` is 0.
- R7: alternating generate and kill positions (for example both operands 0xAAAA, which generates at odd bits and kills at even bits) produce carries only just above the generating bits; a kill stops the carry below it from going further.
- R8: the `TREE_DENSE` and `TREE_SPARSE` settings give identical `sum_o`, `cout_o` and `carry_o` for the same inputs.
- R9: a generate at the lowest position, with propagate at every bit above it, carries out of the top bit (0x0001 + 0xFFFF gives sum 0 and carry-out 1).
- R10: a kill at bit 0 absorbs a carry-in of 1. Bit 0 of the sum becomes 1 and `carry_o[1]` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |
| carry_o | output | WIDTH+1 | Carry into each bit; bit 0 is the carry-in and bit WIDTH is the carry-out |

## Verification
The bench goes after the full-length carry path: all-propagate words with carry-in set, and a single low generate under an all-propagate word. A tree that dropped a level, or swapped high and low in a cell, would lose the carry part way up and give a wrong upper sum and carry-out. Alternating generate/kill words catch a cell that reads the wrong neighbour distance, because a carry would then leak past a kill. A carry-in killed at bit 0 catches a wrong fold-in of the carry-in. The bench runs both tree shapes side by side, so a sparse tree with a missing fill-in cell shows up as a mismatch in only a few middle carries.

// File: rtl/pp_adder_pkg.sv
`timescale 1ns/1ps
package pp_adder_pkg;

    typedef enum logic {
        TREE_DENSE,
        TREE_SPARSE
    } tree_kind_e;

    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Associative, non-commutative carry operator: hi is the more significant span.
    function automatic gp_t gp_merge(input logic hi_g, input logic hi_p,
                                     input logic lo_g, input logic lo_p);
        gp_t r;
        r.g = hi_g | (hi_p & lo_g);
        r.p = hi_p & lo_p;
        return r;
    endfunction

endpackage

// File: rtl/pp_gp_setup.sv
`timescale 1ns/1ps
module pp_gp_setup #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] gen_o,
    output logic [WIDTH-1:0] prop_o
);

    logic [WIDTH-1:0] raw_gen;

    assign raw_gen = a_i & b_i;
    assign prop_o  = a_i ^ b_i;

    // The carry-in occupies the prefix slot below bit 0; fold it into bit 0 here.
    generate
        if (WIDTH > 1) begin : g_upper
            assign gen_o[WIDTH-1:1] = raw_gen[WIDTH-1:1];
        end
    endgenerate
    assign gen_o[0] = raw_gen[0] | (prop_o[0] & cin_i);

endmodule

// File: rtl/pp_tree_dense.sv
`timescale 1ns/1ps
module pp_tree_dense
    import pp_adder_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] gen_i,
    input  logic [WIDTH-1:0] prop_i,
    output logic [WIDTH-1:0] grp_g_o,
    output logic [WIDTH-1:0] grp_p_o
);

    localparam int LEVELS = $clog2(WIDTH);

    logic [WIDTH-1:0] g_s [LEVELS+1];
    logic [WIDTH-1:0] p_s [LEVELS+1];

    assign g_s[0] = gen_i;
    assign p_s[0] = prop_i;

    generate
        for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
            localparam int DIST = 1 << l;
            for (genvar i = 0; i < WIDTH; i++) begin : g_bit
                if (i >= DIST) begin : g_op
                    gp_t r;
                    assign r = gp_merge(g_s[l][i], p_s[l][i],
                                        g_s[l][i-DIST], p_s[l][i-DIST]);
                    assign g_s[l+1][i] = r.g;
                    assign p_s[l+1][i] = r.p;
                end else begin : g_pass
                    assign g_s[l+1][i] = g_s[l][i];
                    assign p_s[l+1][i] = p_s[l][i];
                end
            end
        end
    endgenerate

    assign grp_g_o = g_s[LEVELS];
    assign grp_p_o = p_s[LEVELS];

endmodule

// File: rtl/pp_tree_sparse.sv
`timescale 1ns/1ps
module pp_tree_sparse
    import pp_adder_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] gen_i,
    input  logic [WIDTH-1:0] prop_i,
    output logic [WIDTH-1:0] grp_g_o,
    output logic [WIDTH-1:0] grp_p_o
);

    localparam int LEVELS = $clog2(WIDTH);
    localparam int STAGES = 2 * LEVELS - 1;

    logic [WIDTH-1:0] g_s [STAGES+1];
    logic [WIDTH-1:0] p_s [STAGES+1];

    assign g_s[0] = gen_i;
    assign p_s[0] = prop_i;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Stages below LEVELS sweep upward; the rest fill in downward.
            localparam bit UP   = (s < LEVELS);
            localparam int LVL  = UP ? s : (2 * LEVELS - 2 - s);
            localparam int STEP = 2 << LVL;
            localparam int HALF = 1 << LVL;
            for (genvar i = 0; i < WIDTH; i++) begin : g_bit
                localparam bit ACT = UP ? (((i + 1) % STEP) == 0)
                                        : ((((i + 1) % STEP) == HALF) && (i >= STEP));
                if (ACT) begin : g_op
                    gp_t r;
                    assign r = gp_merge(g_s[s][i], p_s[s][i],
                                        g_s[s][i-HALF], p_s[s][i-HALF]);
                    assign g_s[s+1][i] = r.g;
                    assign p_s[s+1][i] = r.p;
                end else begin : g_pass
                    assign g_s[s+1][i] = g_s[s][i];
                    assign p_s[s+1][i] = p_s[s][i];
                end
            end
        end
    endgenerate

    assign grp_g_o = g_s[STAGES];
    assign grp_p_o = p_s[STAGES];

endmodule

// File: rtl/pp_sum_stage.sv
`timescale 1ns/1ps
module pp_sum_stage #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] prop_i,
    input  logic [WIDTH-1:0] grp_g_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic [WIDTH:0]   carry_o
);

    assign carry_o[0]       = cin_i;
    assign carry_o[WIDTH:1] = grp_g_i;
    assign sum_o            = prop_i ^ carry_o[WIDTH-1:0];

endmodule

// File: rtl/pp_adder.sv
`timescale 1ns/1ps
module pp_adder
    import pp_adder_pkg::*;
#(
    parameter int         WIDTH = 16,
    parameter tree_kind_e TREE  = TREE_DENSE
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic [WIDTH:0]   carry_o
);

    logic [WIDTH-1:0] gen;
    logic [WIDTH-1:0] prop;
    logic [WIDTH-1:0] grp_g;
    logic [WIDTH-1:0] grp_p;

    pp_gp_setup #(.WIDTH(WIDTH)) u_setup (
        .a_i    (a_i),
        .b_i    (b_i),
        .cin_i  (cin_i),
        .gen_o  (gen),
        .prop_o (prop)
    );

    generate
        if (TREE == TREE_SPARSE) begin : g_sparse
            pp_tree_sparse #(.WIDTH(WIDTH)) u_tree (
                .gen_i   (gen),
                .prop_i  (prop),
                .grp_g_o (grp_g),
                .grp_p_o (grp_p)
            );
        end else begin : g_dense
            pp_tree_dense #(.WIDTH(WIDTH)) u_tree (
                .gen_i   (gen),
                .prop_i  (prop),
                .grp_g_o (grp_g),
                .grp_p_o (grp_p)
            );
        end
    endgenerate

    pp_sum_stage #(.WIDTH(WIDTH)) u_sum (
        .prop_i  (prop),
        .grp_g_i (grp_g),
        .cin_i   (cin_i),
        .sum_o   (sum_o),
        .carry_o (carry_o)
    );

    assign cout_o = grp_g[WIDTH-1];

endmodule

// File: rtl/pp_adder_chk.sv
`timescale 1ns/1ps
module pp_adder_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             cin_i,
    input logic [WIDTH-1:0] sum_o,
    input logic             cout_o,
    input logic [WIDTH:0]   carry_o,
    input logic [WIDTH-1:0] grp_p
);

    function automatic logic low_carry(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                                       input logic c, input int k);
        logic [WIDTH:0] m;
        logic [WIDTH:0] t;
        m = ({{WIDTH{1'b0}}, 1'b1} << k) - 1'b1;
        t = ({1'b0, a} & m) + ({1'b0, b} & m) + {{WIDTH{1'b0}}, c};
        return t[k];
    endfunction

    always_comb begin
        // R1
        a_r1_sum_total: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}))
            else $error("a_r1_sum_total");
        // R2
        a_r2_carry_ends: assert (carry_o[0] == cin_i && carry_o[WIDTH] == cout_o)
            else $error("a_r2_carry_ends");
        // R4
        a_r4_sum_bits: assert (sum_o == (a_i ^ b_i ^ carry_o[WIDTH-1:0]))
            else $error("a_r4_sum_bits");
        for (int k = 1; k <= WIDTH; k++) begin
            // R3
            a_r3_prefix_carry: assert (carry_o[k] == low_carry(a_i, b_i, cin_i, k))
                else $error("a_r3_prefix_carry bit %0d", k);
            // R3: group propagate over the low k bits holds only for a run of differing bits
            a_r3_group_prop: assert (grp_p[k-1] == ((~(a_i ^ b_i) & ((WIDTH'(1) << k) - WIDTH'(1))) == '0))
                else $error("a_r3_group_prop bit %0d", k);
        end
    end

endmodule

bind pp_adder pp_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .a_i     (a_i),
    .b_i     (b_i),
    .cin_i   (cin_i),
    .sum_o   (sum_o),
    .cout_o  (cout_o),
    .carry_o (carry_o),
    .grp_p   (grp_p)
);

// File: tb/test_pp_adder.sv
`timescale 1ns/1ps
module test_pp_adder;
    import pp_adder_pkg::*;

    localparam int W = 16;
    localparam int WATCHDOG = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [W-1:0] a, b;
    logic         cin;
    logic [W-1:0] sum_d, sum_s;
    logic         cout_d, cout_s;
    logic [W:0]   car_d, car_s;

    pp_adder #(.WIDTH(W), .TREE(TREE_DENSE)) i_pp_adder (
        .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum_d), .cout_o(cout_d), .carry_o(car_d));

    pp_adder #(.WIDTH(W), .TREE(TREE_SPARSE)) i_pp_adder_sparse (
        .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum_s), .cout_o(cout_s), .carry_o(car_s));

    typedef struct {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] sum;
        logic         cout;
        logic [W:0]   car;
        string        tag;
    } item_t;

    item_t sb_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [W-1:0] ta, input logic [W-1:0] tb, input logic tc, input string tag);
        item_t it;
        logic [W:0] full;
        @(negedge clk);
        a = ta; b = tb; cin = tc;
        full = {1'b0, ta} + {1'b0, tb} + {{W{1'b0}}, tc};
        it.a = ta; it.b = tb; it.tag = tag;
        it.sum = full[W-1:0];
        it.cout = full[W];
        for (int k = 0; k <= W; k++) begin
            logic [W:0] m;
            logic [W:0] t;
            m = ({{W{1'b0}}, 1'b1} << k) - 1'b1;
            t = ({1'b0, ta} & m) + ({1'b0, tb} & m) + {{W{1'b0}}, tc};
            it.car[k] = (k == 0) ? tc : t[k];
        end
        sb_q.push_back(it);
    endtask

    // Monitor: inputs were set on the preceding falling edge; outputs are settled here.
    always @(posedge clk) begin
        if (!rst && sb_q.size() > 0) begin
            item_t e;
            e = sb_q.pop_front();
            check({cout_d, sum_d} == {e.cout, e.sum}, {e.tag, " R1 sum"}, 64'({cout_d, sum_d}), 64'({e.cout, e.sum}));
            check(car_d[0] == cin && car_d[W] == cout_d, {e.tag, " R2 ends"}, 64'({car_d[W], car_d[0]}), 64'({cout_d, cin}));
            check(car_d == e.car, {e.tag, " R3 carries"}, 64'(car_d), 64'(e.car));
            check(sum_d == (e.a ^ e.b ^ car_d[W-1:0]), {e.tag, " R4 sum bits"}, 64'(sum_d), 64'(e.a ^ e.b ^ car_d[W-1:0]));
            check({car_s, cout_s, sum_s} == {car_d, cout_d, sum_d}, {e.tag, " R8 sparse==dense"},
                  64'({car_s, cout_s, sum_s}), 64'({car_d, cout_d, sum_d}));
            check({cout_s, sum_s} == {e.cout, e.sum}, {e.tag, " R8 sparse sum"}, 64'({cout_s, sum_s}), 64'({e.cout, e.sum}));
        end
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        a = '0; b = '0; cin = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        drive(16'h0000, 16'h0000, 1'b0, "R1 idle");
        drive(16'hFFFF, 16'h0000, 1'b1, "R5 all-prop cin1");
        drive(16'h5555, 16'hAAAA, 1'b1, "R5 all-prop mixed cin1");
        drive(16'hFFFF, 16'h0000, 1'b0, "R6 all-prop cin0");
        drive(16'h3C3C, 16'hC3C3, 1'b0, "R6 all-prop mixed cin0");
        drive(16'hAAAA, 16'hAAAA, 1'b0, "R7 gen odd kill even");
        drive(16'h5555, 16'h5555, 1'b1, "R7 gen even kill odd");
        drive(16'hAAAA, 16'hAAAA, 1'b1, "R7 killed cin");
        drive(16'h0001, 16'hFFFF, 1'b0, "R9 low gen full prop");
        drive(16'h0100, 16'hFF00, 1'b0, "R9 mid gen prop above");
        drive(16'h0000, 16'hFFFE, 1'b1, "R10 kill bit0");
        drive(16'hFFFF, 16'hFFFF, 1'b1, "R1 max");
        for (int n = 0; n < 400; n++)
            drive(W'($urandom), W'($urandom), 1'($urandom), "R1 random");
        while (sb_q.size() > 0) @(posedge clk);
        @(negedge clk);
        // R5 and R6 spot checks on the port values directly
        a = 16'hFFFF; b = 16'h0000; cin = 1'b1;
        #1;
        check(sum_d == '0 && cout_d && car_d == '1, "R5 full carry", 64'({car_d, sum_d}), 64'({17'h1FFFF, 16'h0}));
        cin = 1'b0;
        #1;
        check(sum_d == '1 && car_d == '0, "R6 no carry", 64'({car_d, sum_d}), 64'({17'h0, 16'hFFFF}));
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule